// File: doc/BRIEF.md
# Sequential Multi-Limb Unsigned Multiplier

This block multiplies two 256-bit unsigned integers and delivers the exact 512-bit product. It has a single 64x64+64 multiply-add datapath and uses it once per clock. Each operand is split into four 64-bit limbs. For every limb of the first operand, the block walks across the limbs of the second operand and collects a five-limb row: four low words, plus the final high word left in the running carry. It then folds that row into a 512-bit accumulator at the row's limb position, using a single carry chain.

A one-cycle `start` pulse while the block is idle captures both operands and zeroes the accumulator. The block stays `busy` through four rows. Each row takes four multiply cycles and one fold cycle. After that it raises `done` for one cycle. The product sits on `y` from then until the next accepted start.

Top module: `bigmul_top`

## Requirements
- R1: Operands and product use little-endian 64-bit limbs. Limb i of a value covers bits 64*i+63 down to 64*i, so a[127:64]=1 with b[255:192]=1 yields only bit 256 set in y.
- R2: After a run, y equals the exact unsigned product a*b of the operands that were captured, for any operand values.
- R3: With a = b = 2^256-1 the product is exact. Its limbs, from limb 0 upward, are 1, 0, 0, 0, 0xFFFF_FFFF_FFFF_FFFE, then three limbs of all ones.
- R4: A start seen while idle captures a and b. In the following cycle busy is 1.
- R5: done is 1 for exactly one cycle, 20 rising edges after the edge that sampled start. While done is 1, busy is 0.
- R6: While busy, start, a and b have no effect. No extra run follows, and the result belongs to the operands that were first captured.
- R7: The accumulator is zeroed when a start is accepted, so a product never contains anything left over from an earlier run.
- R8: While idle with no start, y holds its value.
- R9: Folding a row into the accumulator never produces a carry out of the top limb.
- R10: While reset is asserted, busy, done and y are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a multiply, sampled only when idle |
| a | input | 256 | First operand, little-endian limbs |
| b | input | 256 | Second operand, little-endian limbs |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle pulse: y holds the new product |
| y | output | 512 | Product, little-endian limbs |

## Verification
The operand pairs are chosen so that a wrong result points to a specific fault:
- The all-ones pair drives the carry into every position of every row and the fold chain.
- Single-limb pairs, such as a limb-1 value times a limb-3 value, expose an offset or limb-order fault.
- One times a dense value and 2^255 times 2 expose a lost top limb or a dropped final carry.
- Zero times a dense value, run right after a large product, exposes stale accumulator contents.
- Pseudo-random dense operands cover general mixing.
- A second start with different operands, issued mid-run, must leave the first product untouched and must not produce a second completion.

// File: rtl/bigmul_pkg.sv
package bigmul_pkg;
  localparam int LIMB_W  = 64;
  localparam int N_LIMBS = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_ACC  = 2'd2
  } mul_state_t;
endpackage

// File: rtl/bigmul_rst_sync.sv
module bigmul_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bigmul_mac.sv
// One multiply-add step: {hi, lo} = x*y + c, which always fits in 2*W bits.
module bigmul_mac #(
  parameter int W = 64
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] c,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  localparam int PW = 2 * W;
  logic [PW-1:0] full;

  assign full = PW'(x) * PW'(y) + PW'(c);
  assign lo   = full[W-1:0];
  assign hi   = full[PW-1:W];
endmodule

// File: rtl/bigmul_row_add.sv
// Adds a ROW_L-limb row into an ACC_L-limb accumulator, starting at limb
// 'offset'. One ripple carry runs through every limb.
module bigmul_row_add #(
  parameter int W     = 64,
  parameter int ACC_L = 8,
  parameter int ROW_L = 5,
  parameter int OW    = 2
) (
  input  logic [ACC_L*W-1:0] acc_in,
  input  logic [ROW_L*W-1:0] row,
  input  logic [OW-1:0]      offset,
  output logic [ACC_L*W-1:0] acc_out,
  output logic               carry_out
);
  logic [ACC_L:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < ACC_L; i++) begin : g_limb
    logic [W-1:0] term;
    always_comb begin
      term = '0;
      for (int k = 0; k < ROW_L; k++) begin
        if (int'(offset) + k == i) term = row[k*W +: W];
      end
    end
    assign {cy[i+1], acc_out[i*W +: W]} =
      {1'b0, acc_in[i*W +: W]} + {1'b0, term} + {{W{1'b0}}, cy[i]};
  end

  assign carry_out = cy[ACC_L];
endmodule

// File: rtl/bigmul_ctrl.sv
module bigmul_ctrl
  import bigmul_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output mul_state_t    state,
  output logic [IW-1:0] row,
  output logic [IW-1:0] col,
  output logic          busy,
  output logic          done
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  mul_state_t    state_d;
  logic [IW-1:0] row_d, col_d;
  logic          done_d;

  always_comb begin
    state_d = state;
    row_d   = row;
    col_d   = col;
    done_d  = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        state_d = ST_MUL;
        row_d   = '0;
        col_d   = '0;
      end
      ST_MUL: begin
        if (col == LAST) state_d = ST_ACC;
        else             col_d   = col + 1'b1;
      end
      ST_ACC: begin
        col_d = '0;
        if (row == LAST) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_MUL;
          row_d   = row + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      row   <= '0;
      col   <= '0;
      done  <= 1'b0;
    end else begin
      state <= state_d;
      row   <= row_d;
      col   <= col_d;
      done  <= done_d;
    end
  end

  assign busy = (state != ST_IDLE);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: rtl/bigmul_top.sv
module bigmul_top
  import bigmul_pkg::*;
#(
  parameter int LW = LIMB_W,
  parameter int NL = N_LIMBS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NL*LW-1:0]  a,
  input  logic [NL*LW-1:0]  b,
  output logic              busy,
  output logic              done,
  output logic [2*NL*LW-1:0] y
);
  localparam int AW = NL * LW;
  localparam int YW = 2 * AW;
  localparam int IW = (NL > 1) ? $clog2(NL) : 1;
  localparam int RL = NL + 1;

  logic          rst_n_s;
  mul_state_t    state;
  logic [IW-1:0] row, col;

  logic [AW-1:0]    a_q, b_q, a_d, b_d;
  logic [RL*LW-1:0] t_q, t_d;
  logic [YW-1:0]    acc_q, acc_d, acc_sum;
  logic [LW-1:0]    mac_c, mac_lo, mac_hi;
  logic             fold_carry;
  logic             ops_en, t_en, acc_en;

  bigmul_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  bigmul_ctrl #(.N(NL), .IW(IW)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n_s),
    .start (start),
    .state (state),
    .row   (row),
    .col   (col),
    .busy  (busy),
    .done  (done)
  );

  // The carry restarts at zero at the first limb of every row.
  assign mac_c = (col == '0) ? '0 : t_q[NL*LW +: LW];

  bigmul_mac #(.W(LW)) u_mac (
    .x  (a_q[row*LW +: LW]),
    .y  (b_q[col*LW +: LW]),
    .c  (mac_c),
    .lo (mac_lo),
    .hi (mac_hi)
  );

  bigmul_row_add #(.W(LW), .ACC_L(2*NL), .ROW_L(RL), .OW(IW)) u_fold (
    .acc_in    (acc_q),
    .row       (t_q),
    .offset    (row),
    .acc_out   (acc_sum),
    .carry_out (fold_carry)
  );

  // Clock enables
  assign ops_en = (state == ST_IDLE) && start;
  assign t_en   = (state == ST_MUL);
  assign acc_en = ops_en || (state == ST_ACC);

  // Next-state values
  always_comb begin
    a_d = a;
    b_d = b;
    t_d = t_q;
    t_d[col*LW +: LW] = mac_lo;
    t_d[NL*LW +: LW]  = mac_hi;
    acc_d = ops_en ? '0 : acc_sum;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      a_q   <= '0;
      b_q   <= '0;
      t_q   <= '0;
      acc_q <= '0;
    end else begin
      if (ops_en) begin
        a_q <= a_d;
        b_q <= b_d;
      end
      if (t_en)   t_q   <= t_d;
      if (acc_en) acc_q <= acc_d;
    end
  end

  assign y = acc_q;

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state == ST_ACC) |-> !fold_carry);
  p_ops_hold_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy |=> ($stable(a_q) && $stable(b_q)));
  p_acc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start && !busy) |=> (y == '0));
  p_y_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && !start) |=> $stable(y));
endmodule

// File: tb/bigmul_top_bench.sv
module bigmul_top_bench;
  localparam int LAT = 20;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [255:0] a_i, b_i;
  logic         busy, done;
  logic [511:0] y;

  int total = 0;
  int fails = 0;
  logic [511:0] exp_q[$];
  string        tag_q[$];
  logic [63:0]  seed = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  bigmul_top u_bigmul_top (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_i),
    .a     (a_i),
    .b     (b_i),
    .busy  (busy),
    .done  (done),
    .y     (y)
  );

  task automatic check(input bit ok, input string req,
                       input logic [511:0] act, input logic [511:0] expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [63:0] next_rand();
    seed ^= seed << 13;
    seed ^= seed >> 7;
    seed ^= seed << 17;
    return seed;
  endfunction

  function automatic logic [255:0] rand256();
    logic [255:0] v;
    for (int i = 0; i < 4; i++) v[i*64 +: 64] = next_rand();
    return v;
  endfunction

  // Monitor: compare every completion against the scoreboard (R2).
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected completion", y, '0);
      end else begin
        logic [511:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(y === e, t, y, e);
      end
    end
  end

  // Driver: one multiply, with optional mid-run disturbance (R6).
  task automatic do_mul(input logic [255:0] av, input logic [255:0] bv,
                        input string req, input bit disturb);
    logic [511:0] ex;
    int n;
    ex = {256'b0, av} * {256'b0, bv};
    while (busy) @(negedge clk);
    a_i = av; b_i = bv; start_i = 1'b1;
    exp_q.push_back(ex);
    tag_q.push_back(req);
    @(negedge clk);
    start_i = 1'b0;
    check(busy === 1'b1, "R4 busy after start", 512'(busy), 512'd1);
    n = 1;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
      if (disturb && n == 4) begin
        a_i = ~av; b_i = ~bv; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
    end
    // start sampled at edge 0; done visible after edge LAT
    check(n == LAT + 1, "R5 latency", 512'(n), 512'(LAT + 1));
    @(negedge clk);
    check(done === 1'b0, "R5 single-cycle done", 512'(done), 512'd0);
    repeat (3) @(negedge clk);
    check(y === ex, "R8 hold after done", y, ex);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R5 watchdog expired", '0, '1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [511:0] ones_prod;
    rst_n = 1'b0; start_i = 1'b0; a_i = '0; b_i = '0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R10 busy in reset", 512'(busy), 512'd0);
    check(done === 1'b0, "R10 done in reset", 512'(done), 512'd0);
    check(y === '0, "R10 y in reset", y, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    do_mul({256{1'b1}}, {256{1'b1}}, "R3 all-ones", 1'b0);
    ones_prod = {{192{1'b1}}, 64'hFFFF_FFFF_FFFF_FFFE, 192'd0, 64'd1};
    check(y === ones_prod, "R3 all-ones limb pattern", y, ones_prod);

    do_mul('0, {256{1'b1}}, "R7 zero after large", 1'b0);
    do_mul({192'd0, 64'd1} << 64, {192'd0, 64'd1} << 192,
           "R1 limb order", 1'b0);
    check(y === (512'd1 << 256), "R1 bit 256 only", y, 512'd1 << 256);
    do_mul(256'd1, 256'hDEAD_BEEF_0123_4567_89AB_CDEF_FEDC_BA98_7654_3210_1111_2222_3333_4444_5555_6666,
           "R2 one times dense", 1'b0);
    do_mul(256'd1 << 255, 256'd2, "R2 top bit carry", 1'b0);
    for (int i = 0; i < 4; i++) begin
      do_mul(rand256(), rand256(), "R2 random", 1'b0);
    end
    do_mul(rand256(), rand256(), "R6 ignored restart", 1'b1);

    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, "R6 no extra run", 512'(exp_q.size()), 512'd0);
    check(busy === 1'b0, "R6 idle after ignored start", 512'(busy), 512'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule